// File: doc/BRIEF.md
# Two-Bank Edge-Triggered Interrupt Line Controller

This block watches a vector of asynchronous request lines and turns selected edges on them into sticky pending flags and single-cycle interrupt pulses. Software can also raise a line by writing a trigger register. A 32-bit register port configures and inspects it. The forty lines are split into a 32-line bank and an 8-line bank. Each bank holds six registers: interrupt enable, event enable, rising select, falling select, software trigger and pending.

A subset of lines are fixed "direct" lines. They are enabled after reset but can never be edge-configured, software-triggered or latched as pending. Pending flags are cleared by writing ones. Clearing a flag also drops the matching software-trigger bit, so the next software write of that bit raises the line again.

Top module: `extint_ctrl`

## Requirements
- R1: After reset the bank 0 enable register (offset 0x00) reads 0xFF820000, the bank 1 enable register (0x20) reads 0x00000087, and every other register reads 0.
- R2: Registers sit at bank base + {0x00 enable, 0x04 event enable, 0x08 rising, 0x0C falling, 0x10 software trigger, 0x14 pending}, with bank 0 at base 0x00 and bank 1 at base 0x20. Reads of any other offset, including offsets with bit 6 or 7 set, unaligned offsets and 0x18/0x1C, return 0. Writes to them change nothing.
- R3: Bank 0 enable and event-enable registers store all 32 bits. Bank 1 stores only bits 7:0 of them and reads bits 31:8 as 0.
- R4: Writes to the rising, falling, software-trigger and pending registers are masked to the non-direct bits. For bank 0 these are the bits of 0x007DFFFF. For bank 1 they are 0x78.
- R5: A rising input edge on an enabled line with its rising-select bit set sets its pending bit. It also drives that line's irq_pulse high for exactly one cycle, sampled three clock edges after the input changes.
- R6: A falling input edge on an enabled line with its falling-select bit set sets pending and pulses the same way.
- R7: An edge has no effect when the line's enable bit is 0 or the matching select bit is 0.
- R8: A software-trigger write stores the masked value. It sets pending and pulses only the bits that are newly set, enabled and not already pending, and the pulse appears one cycle after the write.
- R9: Writing ones to a pending register clears those pending bits and the same software-trigger bits.
- R10: When a hardware edge sets a pending bit in the same cycle as a clear of that bit, the bit stays set.
- R11: Direct lines never become pending.
- R12: A qualified edge on a line that is already pending pulses its output again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| line_in | input | 40 | Asynchronous request lines, bit n is line n |
| irq_pulse | output | 40 | One-cycle interrupt pulse per line |

## Verification
The assertions assume reset is asserted at time zero and that the register port carries at most one write per clock, held steady across the sampling edge. They also assume pending bits can only fall through a pending-clear write. The stimulus changes lines and bus signals only on the falling clock edge and keeps every line low through reset, so the synchroniser never reports an edge left over from reset. The collision case is set up by timing a clear write to land on the exact edge where a synchronised rise is latched.

// File: rtl/extint_pkg.sv
package extint_pkg;

    localparam int DATA_W = 32;

    // register index inside a bank; the order is the address order
    typedef enum logic [2:0] {
        SEL_IMASK = 3'd0,
        SEL_EMASK = 3'd1,
        SEL_RSEL  = 3'd2,
        SEL_FSEL  = 3'd3,
        SEL_SWTRG = 3'd4,
        SEL_PEND  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        logic     bank;
        reg_sel_e sel;
    } reg_dec_t;

endpackage

// File: rtl/extint_decode.sv
module extint_decode
    import extint_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_dec_t          dec
);
    always_comb begin
        dec.hit  = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:6] == '0) && (addr[4:2] <= 3'd5);
        dec.bank = addr[5];
        dec.sel  = reg_sel_e'(addr[4:2]);
    end
endmodule

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int N      = 40,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_in,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    typedef struct packed {
        logic [STAGES-1:0][N-1:0] chain;
        logic [N-1:0]             prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = line_in;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
        st_d.prev = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.chain[STAGES-1] & ~st_q.prev;
    assign fall = ~st_q.chain[STAGES-1] & st_q.prev;
endmodule

// File: rtl/extint_bank.sv
module extint_bank
    import extint_pkg::*;
#(
    parameter int           W      = 32,
    parameter logic [W-1:0] DIRECT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  reg_sel_e     wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] fall,
    output logic [W-1:0] imask,
    output logic [W-1:0] emask,
    output logic [W-1:0] rsel,
    output logic [W-1:0] fsel,
    output logic [W-1:0] swtrg,
    output logic [W-1:0] pend,
    output logic [W-1:0] pulse
);
    localparam logic [W-1:0] TRIG_MASK = ~DIRECT;

    typedef struct packed {
        logic [W-1:0] imask;
        logic [W-1:0] emask;
        logic [W-1:0] rsel;
        logic [W-1:0] fsel;
        logic [W-1:0] swtrg;
        logic [W-1:0] pend;
        logic [W-1:0] pulse;
    } bank_st_t;

    localparam bank_st_t RST = '{imask: DIRECT, default: '0};

    bank_st_t     st_d, st_q;
    logic [W-1:0] hw_set, sw_new, clr, wr_trig;

    always_comb begin
        st_d    = st_q;
        wr_trig = wr_data & TRIG_MASK;
        hw_set  = st_q.imask & ((rise & st_q.rsel) | (fall & st_q.fsel));
        sw_new  = '0;
        clr     = '0;
        if (wr_en) begin
            case (wr_sel)
                SEL_IMASK: st_d.imask = wr_data;
                SEL_EMASK: st_d.emask = wr_data;
                SEL_RSEL:  st_d.rsel  = wr_trig;
                SEL_FSEL:  st_d.fsel  = wr_trig;
                SEL_SWTRG: begin
                    sw_new     = wr_trig & ~st_q.swtrg & st_q.imask & ~st_q.pend;
                    st_d.swtrg = wr_trig;
                end
                SEL_PEND: begin
                    clr        = st_q.pend & wr_trig;
                    st_d.swtrg = st_q.swtrg & ~clr;
                end
                default: ;
            endcase
        end
        // a set in the same cycle as a clear wins
        st_d.pend  = (st_q.pend & ~clr) | hw_set | sw_new;
        st_d.pulse = hw_set | sw_new;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST;
        else        st_q <= st_d;
    end

    assign imask = st_q.imask;
    assign emask = st_q.emask;
    assign rsel  = st_q.rsel;
    assign fsel  = st_q.fsel;
    assign swtrg = st_q.swtrg;
    assign pend  = st_q.pend;
    assign pulse = st_q.pulse;
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int          B0_LINES    = 32,
    parameter int          B1_LINES    = 8,
    parameter logic [31:0] B0_DIRECT   = 32'hFF82_0000,
    parameter logic [31:0] B1_DIRECT   = 32'h0000_0087,
    parameter int          ADDR_W      = 8,
    parameter int          SYNC_STAGES = 2,
    localparam int         LINES       = B0_LINES + B1_LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [LINES-1:0]  line_in,
    output logic [LINES-1:0]  irq_pulse
);
    reg_dec_t            dec;
    logic [LINES-1:0]    sync_rise, sync_fall;
    logic [B0_LINES-1:0] b0_imask, b0_emask, b0_rsel, b0_fsel, b0_swtrg, b0_pend, b0_pulse;
    logic [B1_LINES-1:0] b1_imask, b1_emask, b1_rsel, b1_fsel, b1_swtrg, b1_pend, b1_pulse;
    logic [5:0][DATA_W-1:0] view0, view1;

    extint_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    extint_sync #(.N(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .rise    (sync_rise),
        .fall    (sync_fall)
    );

    extint_bank #(.W(B0_LINES), .DIRECT(B0_DIRECT[B0_LINES-1:0])) u_bank0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr && dec.hit && !dec.bank),
        .wr_sel  (dec.sel),
        .wr_data (bus_wdata[B0_LINES-1:0]),
        .rise    (sync_rise[B0_LINES-1:0]),
        .fall    (sync_fall[B0_LINES-1:0]),
        .imask   (b0_imask),
        .emask   (b0_emask),
        .rsel    (b0_rsel),
        .fsel    (b0_fsel),
        .swtrg   (b0_swtrg),
        .pend    (b0_pend),
        .pulse   (b0_pulse)
    );

    extint_bank #(.W(B1_LINES), .DIRECT(B1_DIRECT[B1_LINES-1:0])) u_bank1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr && dec.hit && dec.bank),
        .wr_sel  (dec.sel),
        .wr_data (bus_wdata[B1_LINES-1:0]),
        .rise    (sync_rise[LINES-1:B0_LINES]),
        .fall    (sync_fall[LINES-1:B0_LINES]),
        .imask   (b1_imask),
        .emask   (b1_emask),
        .rsel    (b1_rsel),
        .fsel    (b1_fsel),
        .swtrg   (b1_swtrg),
        .pend    (b1_pend),
        .pulse   (b1_pulse)
    );

    always_comb begin
        view0[SEL_IMASK] = DATA_W'(b0_imask);
        view0[SEL_EMASK] = DATA_W'(b0_emask);
        view0[SEL_RSEL]  = DATA_W'(b0_rsel);
        view0[SEL_FSEL]  = DATA_W'(b0_fsel);
        view0[SEL_SWTRG] = DATA_W'(b0_swtrg);
        view0[SEL_PEND]  = DATA_W'(b0_pend);
        view1[SEL_IMASK] = DATA_W'(b1_imask);
        view1[SEL_EMASK] = DATA_W'(b1_emask);
        view1[SEL_RSEL]  = DATA_W'(b1_rsel);
        view1[SEL_FSEL]  = DATA_W'(b1_fsel);
        view1[SEL_SWTRG] = DATA_W'(b1_swtrg);
        view1[SEL_PEND]  = DATA_W'(b1_pend);
        bus_rdata = '0;
        if (dec.hit) begin
            bus_rdata = dec.bank ? view1[dec.sel] : view0[dec.sel];
        end
    end

    assign irq_pulse = {b1_pulse, b0_pulse};
endmodule

// File: rtl/extint_chk.sv
module extint_chk #(
    parameter int          B0_LINES  = 32,
    parameter int          B1_LINES  = 8,
    parameter logic [31:0] B0_DIRECT = 32'hFF82_0000,
    parameter logic [31:0] B1_DIRECT = 32'h0000_0087,
    parameter int          ADDR_W    = 8,
    localparam int         LINES     = B0_LINES + B1_LINES
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [LINES-1:0]    irq_pulse,
    input logic [LINES-1:0]    pend_all,
    input logic [B1_LINES-1:0] rsel1,
    input logic [B1_LINES-1:0] fsel1,
    input logic [B1_LINES-1:0] swtrg1
);
    localparam logic [LINES-1:0] DIRECT_ALL = {B1_DIRECT[B1_LINES-1:0], B0_DIRECT[B0_LINES-1:0]};

    assert_direct_never_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_all & DIRECT_ALL) == '0);

    assert_pulse_leaves_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse & ~pend_all) == '0);

    assert_new_pending_pulses_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_all & ~$past(pend_all)) & ~irq_pulse) == '0);

    assert_clear_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(pend_all) & ~pend_all)) |->
            ($past(bus_wr) && ($past(bus_addr) == ADDR_W'('h14) || $past(bus_addr) == ADDR_W'('h34))));

    assert_bank1_trig_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((rsel1 | fsel1 | swtrg1) & B1_DIRECT[B1_LINES-1:0]) == '0);
endmodule

bind extint_ctrl extint_chk #(
    .B0_LINES  (B0_LINES),
    .B1_LINES  (B1_LINES),
    .B0_DIRECT (B0_DIRECT),
    .B1_DIRECT (B1_DIRECT),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .irq_pulse (irq_pulse),
    .pend_all  ({b1_pend, b0_pend}),
    .rsel1     (b1_rsel),
    .fsel1     (b1_fsel),
    .swtrg1    (b1_swtrg)
);

// File: tb/tb_extint_ctrl.sv
module tb_extint_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [39:0] line_in = '0;
    logic [39:0] irq_pulse;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    extint_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .line_in   (line_in),
        .irq_pulse (irq_pulse)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] m_reg [2][6];
    logic [39:0] m_s1, m_s2, m_prev, m_pulse;

    function automatic logic [31:0] valid_bits(int b);
        return (b == 1) ? 32'h0000_00FF : 32'hFFFF_FFFF;
    endfunction
    function automatic logic [31:0] trig_bits(int b);
        return (b == 1) ? 32'h0000_0078 : 32'h007D_FFFF;
    endfunction
    function automatic logic [31:0] m_read(logic [7:0] a);
        if (a[1:0] == 0 && a[7:6] == 0 && a[4:2] <= 5) return m_reg[a[5]][a[4:2]];
        return 32'h0;
    endfunction

    always @(posedge clk) begin : model
        logic [39:0] rise, fall;
        logic [31:0] hw [2];
        logic [31:0] sw [2];
        logic [31:0] v, clr;
        int b, k;
        if (!rst_n) begin
            for (int bb = 0; bb < 2; bb++) for (int r = 0; r < 6; r++) m_reg[bb][r] = 32'h0;
            m_reg[0][0] = 32'hFF82_0000;
            m_reg[1][0] = 32'h0000_0087;
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_pulse = '0;
        end else begin
            rise = m_s2 & ~m_prev;
            fall = ~m_s2 & m_prev;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = line_in;
            for (int bb = 0; bb < 2; bb++) begin
                hw[bb] = 0; sw[bb] = 0;
                for (int i = 0; i < ((bb == 1) ? 8 : 32); i++) begin
                    if (m_reg[bb][0][i] && ((rise[bb*32+i] && m_reg[bb][2][i]) ||
                                            (fall[bb*32+i] && m_reg[bb][3][i])))
                        hw[bb][i] = 1'b1;
                end
            end
            if (bus_wr && bus_addr[1:0] == 0 && bus_addr[7:6] == 0 && bus_addr[4:2] <= 5) begin
                b = bus_addr[5];
                k = bus_addr[4:2];
                case (k)
                    0, 1: m_reg[b][k] = bus_wdata & valid_bits(b);
                    2, 3: m_reg[b][k] = bus_wdata & trig_bits(b);
                    4: begin
                        v = bus_wdata & trig_bits(b);
                        sw[b] = v & ~m_reg[b][4] & m_reg[b][0] & ~m_reg[b][5];
                        m_reg[b][4] = v;
                    end
                    default: begin
                        clr = m_reg[b][5] & bus_wdata & trig_bits(b);
                        m_reg[b][5] = m_reg[b][5] & ~clr;
                        m_reg[b][4] = m_reg[b][4] & ~clr;
                    end
                endcase
            end
            for (int bb = 0; bb < 2; bb++) m_reg[bb][5] = m_reg[bb][5] | hw[bb] | sw[bb];
            m_pulse = {hw[1][7:0] | sw[1][7:0], hw[0] | sw[0]};
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            chk("R5/R6/R8 pulse vs model", irq_pulse, m_pulse);
            chk("R2 read vs model", bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic set_line(int n, logic v, int wait_cycles);
        @(negedge clk);
        line_in[n] = v;
        repeat (wait_cycles) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(8'h00, 32'hFF82_0000, "R1 bank0 enable");
        rd(8'h20, 32'h0000_0087, "R1 bank1 enable");
        rd(8'h08, 32'h0, "R1 rising");
        rd(8'h34, 32'h0, "R1 pending");
        rd(8'h10, 32'h0, "R1 swtrg");

        // R3 mask widths
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, 32'hFFFF_FFFF, "R3 bank0 enable");
        wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, 32'h0000_00FF, "R3 bank1 enable");
        wr(8'h04, 32'hA5A5_A5A5); rd(8'h04, 32'hA5A5_A5A5, "R3 bank0 event");
        wr(8'h24, 32'hFFFF_1234); rd(8'h24, 32'h0000_0034, "R3 bank1 event");

        // R4 trigger masking
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, 32'h007D_FFFF, "R4 bank0 rising");
        wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, 32'h0000_0078, "R4 bank1 rising");
        wr(8'h2C, 32'hFFFF_FFFF); rd(8'h2C, 32'h0000_0078, "R4 bank1 falling");

        // R2 undefined offsets
        wr(8'h09, 32'h0); rd(8'h08, 32'h007D_FFFF, "R2 unaligned write ignored");
        wr(8'h48, 32'h0); rd(8'h08, 32'h007D_FFFF, "R2 high offset write ignored");
        rd(8'h18, 32'h0, "R2 hole read");
        rd(8'h1C, 32'h0, "R2 hole read 1C");
        rd(8'h09, 32'h0, "R2 unaligned read");

        // R5 rising edge latency and pulse width
        @(negedge clk); line_in[3] = 1'b1;
        repeat (3) @(negedge clk);
        #1 chk("R5 pulse on third edge", irq_pulse[3], 1'b1);
        @(negedge clk);
        #1 chk("R5 pulse one cycle", irq_pulse[3], 1'b0);
        rd(8'h14, 32'h0000_0008, "R5 pending");

        // R9 clear
        wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, 32'h0, "R9 clear all");

        // R6 / R7 select
        wr(8'h08, 32'h0); wr(8'h0C, 32'h0000_0020);
        set_line(5, 1'b1, 5); rd(8'h14, 32'h0, "R7 rise not selected");
        set_line(5, 1'b0, 5); rd(8'h14, 32'h0000_0020, "R6 falling edge");

        // R7 enable off
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FF7F); wr(8'h0C, 32'h0000_00A0);
        set_line(7, 1'b1, 5); set_line(7, 1'b0, 5);
        rd(8'h14, 32'h0, "R7 disabled line");

        // R8 software trigger
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h10, 32'h8000_0003);
        #1 chk("R8 sw pulse", irq_pulse, 40'h3);
        rd(8'h14, 32'h3, "R8 sw pending");
        rd(8'h10, 32'h3, "R8 sw stored masked");
        wr(8'h10, 32'h3);
        #1 chk("R8 no repeat pulse", irq_pulse, 40'h0);
        wr(8'h14, 32'h1);
        rd(8'h14, 32'h2, "R9 partial clear");
        rd(8'h10, 32'h2, "R9 swtrg cleared");
        wr(8'h10, 32'h3);
        #1 chk("R8 only new bit pulses", irq_pulse, 40'h1);
        rd(8'h14, 32'h3, "R8 pending after retrigger");
        wr(8'h30, 32'hFF);
        #1 chk("R8 bank1 pulse", irq_pulse[39:32], 8'h78);
        rd(8'h30, 32'h78, "R8 bank1 swtrg");
        rd(8'h34, 32'h78, "R8 bank1 pending");
        wr(8'h34, 32'hFF); rd(8'h34, 32'h0, "R9 bank1 clear");
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFE); wr(8'h10, 32'h1);
        rd(8'h14, 32'h0, "R8 masked sw no pending");
        wr(8'h00, 32'hFFFF_FFFF); wr(8'h10, 32'h0);

        // R11 direct lines
        wr(8'h08, 32'h0002_0008); rd(8'h08, 32'h0000_0008, "R11 rising direct bit");
        wr(8'h10, 32'h0002_0000); rd(8'h14, 32'h0, "R11 sw direct");
        set_line(17, 1'b1, 5); set_line(17, 1'b0, 5);
        rd(8'h14, 32'h0, "R11 edge on direct line");

        // R10 / R12 collision and repeat pulse
        set_line(3, 1'b0, 5);
        set_line(3, 1'b1, 5);
        rd(8'h14, 32'h8, "R5 pending again");
        set_line(3, 1'b0, 5);
        @(negedge clk); line_in[3] = 1'b1;
        @(negedge clk);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h8;
        @(negedge clk); bus_wr = 1'b0;
        #1 chk("R12 pulse on pending line", irq_pulse[3], 1'b1);
        rd(8'h14, 32'h8, "R10 set wins over clear");
        wr(8'h14, 32'h8); rd(8'h14, 32'h0, "R9 clear after collision");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule